// File: doc/BRIEF.md
# Audio Playback Status Controller

This block sequences playback for an isochronous audio sink. It watches whether the bus is configured and whether it is suspended. It also sees a strobe for each received packet, where one packet holds one millisecond of samples, an end-of-stream indication and a buffer-empty indication. From these it decides when the downstream sample datapath may run. While no playback is under way, it forces the analog path to a silent output.

The block also drives three status flags: an active-low playing flag, an active-low suspended flag and an active-high all-zero flag. The all-zero flag is fed by a per-sample strobe together with the current left and right sample values. It rises once a run of exactly `ZERO_RUN` zero-valued sample periods has been seen, and it is held high while the block waits for data or sits idle. The sequencer has five states: idle, waiting for data, priming, playing and draining.

Top module: `pbk_status_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it with the bus unconfigured, the outputs are play_en_o=0, force_zero_o=1, play_n_o=1, susp_n_o=1 and zero_o=1.
- R2: From idle, when cfg_i=1 and susp_i=0 at a clock edge, the block moves to waiting for data. play_en_o stays 0 and force_zero_o stays 1.
- R3: Playback starts only after a whole packet has been buffered. The first pkt_i strobe while waiting for data enters priming, with no playback. The next pkt_i strobe in priming starts playing: play_en_o=1, force_zero_o=0 and play_n_o=0 from the cycle after that edge.
- R4: eos_i while playing enters draining, and playback continues. buf_empty_i while draining returns the block to waiting for data, with play_n_o=1 and play_en_o=0 from the next cycle. buf_empty_i while playing has no effect.
- R5: susp_i=1 at any edge sends the block to idle with playback disabled. This takes priority over every other input. susp_n_o equals the inverse of susp_i sampled at the previous edge.
- R6: cfg_i=0 with susp_i=0 at any edge sends the block to idle.
- R7: A sample period is an edge with smp_stb_i=1. It counts as zero when both smp_l_i and smp_r_i are all zeros. zero_o rises in the cycle after the ZERO_RUN-th (default 102) consecutive zero period, and not after the one before it.
- R8: A sample period with any nonzero bit on either channel clears the run, and zero_o falls in the next cycle unless R10 holds it.
- R9: The zero run saturates at ZERO_RUN instead of wrapping, so further zero periods keep zero_o high. After a clear, a full new run of ZERO_RUN is needed.
- R10: While idle or waiting for data, zero_o is held at 1 whatever the samples are.
- R11: Sample values on edges with smp_stb_i=0 are ignored and leave zero_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 1 | Bus connection configured |
| susp_i | input | 1 | Bus in suspend |
| pkt_i | input | 1 | One 1 ms packet received (one-cycle strobe) |
| eos_i | input | 1 | Host has stopped the stream |
| buf_empty_i | input | 1 | Sample buffer has drained |
| smp_stb_i | input | 1 | One sample period |
| smp_l_i | input | SW | Left sample |
| smp_r_i | input | SW | Right sample |
| play_en_o | output | 1 | Datapath playback enable |
| force_zero_o | output | 1 | Force analog output to silence |
| play_n_o | output | 1 | Playing flag, active low |
| susp_n_o | output | 1 | Suspended flag, active low |
| zero_o | output | 1 | All-zero flag, active high |

## Verification
The hardest situation to reach is the boundary of the zero run during live playback. zero_o has to stay low through 101 zero periods, rise on the 102nd, saturate, and then clear on a single nonzero value on only one channel. This all has to happen while the sequencer is in a state that does not force the flag high. The stimulus first primes the block with two packet strobes so it is playing. Loops then drive exact counts of zero strobes, interleaved with idle cycles that carry nonzero data but no strobe. A reference model in the bench predicts every output on every cycle.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_PRIME = 3'd2,
    ST_PLAY  = 3'd3,
    ST_DRAIN = 3'd4
  } pbk_state_e;

  // Playback is live in the play and drain states
  function automatic logic is_playing(input pbk_state_e s);
    return (s == ST_PLAY) || (s == ST_DRAIN);
  endfunction

  // States in which the zero flag is forced high
  function automatic logic holds_zero(input pbk_state_e s);
    return (s == ST_IDLE) || (s == ST_WAIT);
  endfunction

  // Next zero-run value: clear on nonzero, else saturating increment
  function automatic int unsigned zero_run_next(input int unsigned cur,
                                                input int unsigned cap,
                                                input logic nonzero);
    if (nonzero) return 0;
    if (cur >= cap) return cap;
    return cur + 1;
  endfunction

endpackage

// File: rtl/pbk_seq.sv
module pbk_seq
  import pbk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_i,
  input  logic       susp_i,
  input  logic       pkt_i,
  input  logic       eos_i,
  input  logic       buf_empty_i,
  output pbk_state_e state_o,
  output logic       ev_start_o,
  output logic       ev_drained_o
);

  pbk_state_e state_q, state_d;
  logic       link_up;

  assign link_up = cfg_i && !susp_i;

  always_comb begin
    state_d = state_q;
    if (!link_up) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_WAIT;
        ST_WAIT:  if (pkt_i)       state_d = ST_PRIME;
        ST_PRIME: if (pkt_i)       state_d = ST_PLAY;
        ST_PLAY:  if (eos_i)       state_d = ST_DRAIN;
        ST_DRAIN: if (buf_empty_i) state_d = ST_WAIT;
        default:                   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o      = state_q;
  assign ev_start_o   = link_up && (state_q == ST_PRIME) && pkt_i;
  assign ev_drained_o = link_up && (state_q == ST_DRAIN) && buf_empty_i;

endmodule

// File: rtl/pbk_zero_det.sv
module pbk_zero_det #(
  parameter int unsigned SW       = 16,
  parameter int unsigned NCH      = 2,
  parameter int unsigned ZERO_RUN = 102,
  localparam int unsigned CW      = $clog2(ZERO_RUN + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stb_i,
  input  logic [NCH-1:0][SW-1:0]  smp_i,
  output logic [CW-1:0]           cnt_o,
  output logic                    full_o,
  output logic                    nonzero_o
);

  logic [NCH-1:0] ch_nz;
  logic [CW-1:0]  cnt_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_nz[c] = |smp_i[c];
  end

  assign nonzero_o = |ch_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (stb_i) begin
      cnt_q <= CW'(pbk_pkg::zero_run_next(32'(cnt_q), ZERO_RUN, nonzero_o));
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CW'(ZERO_RUN));

endmodule

// File: rtl/pbk_flags.sv
module pbk_flags
  import pbk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pbk_state_e state_i,
  input  logic       susp_i,
  input  logic       run_full_i,
  output logic       play_en_o,
  output logic       force_zero_o,
  output logic       play_n_o,
  output logic       susp_n_o,
  output logic       zero_o,
  output logic       hold_o
);

  logic susp_q;
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) susp_q <= 1'b0;
    else        susp_q <= susp_i;
  end

  assign live         = is_playing(state_i);
  assign hold_o       = holds_zero(state_i);
  assign play_en_o    = live;
  assign force_zero_o = !live;
  assign play_n_o     = !live;
  assign susp_n_o     = !susp_q;
  assign zero_o       = hold_o || run_full_i;

endmodule

// File: rtl/pbk_status_ctrl.sv
module pbk_status_ctrl
  import pbk_pkg::*;
#(
  parameter int unsigned SW       = 16,
  parameter int unsigned ZERO_RUN = 102,
  localparam int unsigned NCH     = 2,
  localparam int unsigned CW      = $clog2(ZERO_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_i,
  input  logic          susp_i,
  input  logic          pkt_i,
  input  logic          eos_i,
  input  logic          buf_empty_i,
  input  logic          smp_stb_i,
  input  logic [SW-1:0] smp_l_i,
  input  logic [SW-1:0] smp_r_i,
  output logic          play_en_o,
  output logic          force_zero_o,
  output logic          play_n_o,
  output logic          susp_n_o,
  output logic          zero_o
);

  pbk_state_e           st_w;
  logic                 ev_start_w;
  logic                 ev_drained_w;
  logic [CW-1:0]        zcnt_w;
  logic                 zfull_w;
  logic                 nonzero_w;
  logic                 hold_w;
  logic [NCH-1:0][SW-1:0] smp_w;

  assign smp_w[0] = smp_l_i;
  assign smp_w[1] = smp_r_i;

  pbk_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_i        (cfg_i),
    .susp_i       (susp_i),
    .pkt_i        (pkt_i),
    .eos_i        (eos_i),
    .buf_empty_i  (buf_empty_i),
    .state_o      (st_w),
    .ev_start_o   (ev_start_w),
    .ev_drained_o (ev_drained_w)
  );

  pbk_zero_det #(.SW(SW), .NCH(NCH), .ZERO_RUN(ZERO_RUN)) u_zero (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_i     (smp_stb_i),
    .smp_i     (smp_w),
    .cnt_o     (zcnt_w),
    .full_o    (zfull_w),
    .nonzero_o (nonzero_w)
  );

  pbk_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_i      (st_w),
    .susp_i       (susp_i),
    .run_full_i   (zfull_w),
    .play_en_o    (play_en_o),
    .force_zero_o (force_zero_o),
    .play_n_o     (play_n_o),
    .susp_n_o     (susp_n_o),
    .zero_o       (zero_o),
    .hold_o       (hold_w)
  );

endmodule

// File: rtl/pbk_status_chk.sv
module pbk_status_chk #(
  parameter int unsigned SW       = 16,
  parameter int unsigned ZERO_RUN = 102,
  localparam int unsigned CW      = $clog2(ZERO_RUN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_i,
  input logic          susp_i,
  input logic          pkt_i,
  input logic          smp_stb_i,
  input logic [SW-1:0] smp_l_i,
  input logic [SW-1:0] smp_r_i,
  input logic          play_en_o,
  input logic          play_n_o,
  input logic          susp_n_o,
  input logic          zero_o,
  input logic          ev_drained_w,
  input logic          hold_w,
  input logic [CW-1:0] zcnt_w
);

  AST_PLAY_AFTER_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(play_en_o) |-> $past(pkt_i)); // R3

  AST_DRAIN_STOPS_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drained_w |=> play_n_o); // R4

  AST_SUSPEND_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    susp_i |=> (!play_en_o && !susp_n_o)); // R5

  AST_UNCONFIG_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i |=> play_n_o); // R6

  AST_NONZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb_i && ((|smp_l_i) || (|smp_r_i))) |=> (zero_o == hold_w)); // R8

  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    zcnt_w <= CW'(ZERO_RUN)); // R9

  AST_NO_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb_i |=> $stable(zcnt_w)); // R11

endmodule

bind pbk_status_ctrl pbk_status_chk #(.SW(SW), .ZERO_RUN(ZERO_RUN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_i        (cfg_i),
  .susp_i       (susp_i),
  .pkt_i        (pkt_i),
  .smp_stb_i    (smp_stb_i),
  .smp_l_i      (smp_l_i),
  .smp_r_i      (smp_r_i),
  .play_en_o    (play_en_o),
  .play_n_o     (play_n_o),
  .susp_n_o     (susp_n_o),
  .zero_o       (zero_o),
  .ev_drained_w (ev_drained_w),
  .hold_w       (hold_w),
  .zcnt_w       (zcnt_w)
);

// File: tb/pbk_status_ctrl_tb_top.sv
module pbk_status_ctrl_tb_top;

  localparam int RUN = 102;

  typedef struct {
    logic  play_en;
    logic  force_zero;
    logic  play_n;
    logic  susp_n;
    logic  zero;
    string req;
  } exp_t;

  localparam int M_IDLE = 0, M_WAIT = 1, M_PRIME = 2, M_PLAY = 3, M_DRAIN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg = 1'b0, susp = 1'b0, pkt = 1'b0, eos = 1'b0, empty = 1'b0, stb = 1'b0;
  logic [15:0] sl = '0, sr = '0;
  logic        play_en, force_zero, play_n, susp_n, zero;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  exp_t q[$];
  int   m_st   = M_IDLE;
  int   m_run  = 0;

  always #10 clk = ~clk;

  pbk_status_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .susp_i(susp), .pkt_i(pkt),
    .eos_i(eos), .buf_empty_i(empty), .smp_stb_i(stb), .smp_l_i(sl), .smp_r_i(sr),
    .play_en_o(play_en), .force_zero_o(force_zero), .play_n_o(play_n),
    .susp_n_o(susp_n), .zero_o(zero)
  );

  task automatic compare(input exp_t e);
    logic [4:0] act, ex;
    act = {play_en, force_zero, play_n, susp_n, zero};
    ex  = {e.play_en, e.force_zero, e.play_n, e.susp_n, e.zero};
    checks++;
    if (act !== ex) begin
      fails++;
      $display("FAIL %s actual{en,fz,pn,sn,z}=%b expected=%b at %0t", e.req, act, ex, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the predicted outputs
  task automatic drive(input logic c, input logic s, input logic p, input logic e,
                       input logic m, input logic st, input logic [15:0] l,
                       input logic [15:0] r, input string req);
    int   ns;
    exp_t x;
    @(negedge clk);
    cfg = c; susp = s; pkt = p; eos = e; empty = m; stb = st; sl = l; sr = r;
    ns = m_st;
    if (s || !c) ns = M_IDLE;
    else case (m_st)
      M_IDLE:  ns = M_WAIT;
      M_WAIT:  if (p) ns = M_PRIME;
      M_PRIME: if (p) ns = M_PLAY;
      M_PLAY:  if (e) ns = M_DRAIN;
      M_DRAIN: if (m) ns = M_WAIT;
      default: ns = M_IDLE;
    endcase
    if (st) begin
      if (l != 16'h0 || r != 16'h0) m_run = 0;
      else if (m_run < RUN) m_run = m_run + 1;
    end
    m_st = ns;
    x.play_en    = (ns == M_PLAY || ns == M_DRAIN);
    x.force_zero = !x.play_en;
    x.play_n     = !x.play_en;
    x.susp_n     = !s;
    x.zero       = (ns == M_IDLE || ns == M_WAIT) || (m_run == RUN);
    x.req        = req;
    q.push_back(x);
  endtask

  // Monitor: pops one expectation per cycle, a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  task automatic zeros(input int n, input string req);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 0, 0, 1, 16'h0, 16'h0, req);
  endtask

  initial begin
    exp_t r0;
    #5;
    r0.play_en = 0; r0.force_zero = 1; r0.play_n = 1; r0.susp_n = 1; r0.zero = 1;
    r0.req = "R1 in-reset";
    compare(r0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 16'h0, 16'h0, "R1 post-reset");
    drive(0, 0, 1, 0, 0, 0, 16'h0, 16'h0, "R6 unconfigured ignores pkt");
    drive(1, 0, 0, 0, 0, 1, 16'h1234, 16'h0, "R2 enter wait");
    drive(1, 0, 0, 0, 0, 1, 16'h0, 16'h5, "R10 hold in wait");
    drive(1, 0, 1, 0, 0, 0, 16'h0, 16'h0, "R3 first packet primes");
    drive(1, 0, 0, 0, 0, 0, 16'h0, 16'h0, "R3 priming no play");
    drive(1, 0, 0, 1, 1, 0, 16'h0, 16'h0, "R3 prime ignores eos");
    drive(1, 0, 1, 0, 0, 1, 16'h7, 16'h0, "R3 second packet plays");
    drive(1, 0, 0, 0, 1, 0, 16'h0, 16'h0, "R4 empty ignored in play");
    zeros(RUN - 1, "R7 below run");
    drive(1, 0, 0, 0, 0, 0, 16'hFFFF, 16'h1, "R11 no strobe below run");
    zeros(1, "R7 run reached");
    zeros(5, "R9 saturate");
    drive(1, 0, 0, 0, 0, 0, 16'h8000, 16'h8000, "R11 no strobe at full");
    drive(1, 0, 0, 0, 0, 1, 16'h0, 16'h0001, "R8 right nonzero clears");
    zeros(RUN - 1, "R9 new run needed");
    drive(1, 0, 0, 0, 0, 1, 16'h8000, 16'h0, "R8 left nonzero clears");
    zeros(RUN, "R7 second run");
    drive(1, 0, 0, 1, 0, 0, 16'h0, 16'h0, "R4 eos drains");
    drive(1, 0, 0, 0, 0, 0, 16'h0, 16'h0, "R4 drain keeps playing");
    drive(1, 0, 0, 0, 1, 0, 16'h0, 16'h0, "R4 empty ends drain");
    drive(1, 0, 1, 0, 0, 0, 16'h0, 16'h0, "R3 reprime");
    drive(1, 0, 1, 0, 0, 0, 16'h0, 16'h0, "R3 replay");
    drive(1, 1, 1, 1, 1, 1, 16'h3, 16'h3, "R5 suspend from play");
    drive(1, 1, 0, 0, 0, 0, 16'h0, 16'h0, "R5 stay suspended");
    drive(1, 0, 0, 0, 0, 0, 16'h0, 16'h0, "R5 resume to wait");
    drive(1, 0, 1, 0, 0, 0, 16'h0, 16'h0, "R3 prime again");
    drive(1, 1, 1, 0, 0, 0, 16'h0, 16'h0, "R5 suspend beats packet");
    drive(1, 0, 0, 0, 0, 0, 16'h0, 16'h0, "R2 wait again");
    drive(1, 0, 1, 0, 0, 0, 16'h0, 16'h0, "R3 prime");
    drive(1, 0, 1, 0, 0, 0, 16'h0, 16'h0, "R3 play");
    drive(0, 0, 0, 0, 0, 0, 16'h0, 16'h0, "R6 unconfigure idles");
    drive(0, 0, 0, 0, 0, 0, 16'h0, 16'h0, "R6 stay idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule